// File: doc/BRIEF.md
# Flash Write Gate and Sector Lock Controller

This block sits in front of a byte-wide 512K x 8 NOR flash model and decides which bus activity may reach the array. It passes the asynchronous chip-enable, output-enable and write-enable strobes through synchronizers. It accepts a write only when the strobes have shown a valid write combination for long enough to rule out a glitch. After reset it refuses all writes until the strobes have been seen idle high. At the end of each accepted write cycle it emits a single-cycle `wr_pulse` for a downstream command decoder.

The same block maps every 19-bit byte address onto one of eleven sectors of a bottom-boot layout. It keeps one lock bit for each sector. Program and erase requests from the command decoder are either granted or rejected against those bits. A rejection raises a one-cycle `blocked` pulse that carries the sector number. A temporary-unlock input overrides every lock while it is held. Because the stored bits are never altered by that input, the previous protection returns when it is released. Locks are set one sector at a time. They are cleared all together, and only when every sector is already locked. A query reads back any sector's stored lock bit.

Top module: `flash_wrgate`

## Requirements
- R1: A write is qualified only while chip enable (`ce_n`) and write enable (`we_n`) are both low and output enable (`oe_n`) is high. `oe_n` low, `ce_n` high or `we_n` high each prevent a write.
- R2: A low phase of the write combination lasting fewer than `GLITCH_CYC` clock cycles produces no write. A phase of `GLITCH_CYC` cycles or more produces exactly one `wr_pulse` when the combination ends.
- R3: If the write combination is present when reset is released, no write is accepted until `ce_n` and `we_n` have both been seen high at the same time.
- R4: After reset every sector is unlocked, and all pulse outputs are low.
- R5: `sector` is a combinational function of `addr`, as follows:
  - 0x00000–0x03FFF → 0
  - 0x04000–0x05FFF → 1
  - 0x06000–0x07FFF → 2
  - 0x08000–0x0FFFF → 3
  - each following 64 KB block → 4 up to 10
- R6: A program or erase request to a locked sector gives no grant. In the next cycle `blocked` is high and `blk_sector` holds the sector number. A request to an unlocked sector raises `prog_go` or `erase_go` in the next cycle.
- R7: While `tmp_unprot` is high (after synchronization), locked sectors grant program and erase requests. After it falls, those sectors reject requests again.
- R8: `unprot_req` clears all lock bits and pulses `unprot_done` only when all eleven sectors are locked. Otherwise it changes nothing and gives no `unprot_done`.
- R9: `qry_req` yields `qry_valid` in the next cycle, with `qry_prot` equal to the stored lock bit of the addressed sector. The temporary unlock does not affect this value.
- R10: `wr_pulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| tmp_unprot | input | 1 | Temporary unlock flag, asynchronous |
| addr | input | 19 | Byte address used for the sector lookup |
| prog_req | input | 1 | Program request for the sector of `addr` |
| erase_req | input | 1 | Erase request for the sector of `addr` |
| prot_set_req | input | 1 | Lock the sector of `addr` |
| unprot_req | input | 1 | Clear all locks if all are set |
| qry_req | input | 1 | Query the lock bit of the sector of `addr` |
| wr_pulse | output | 1 | One-cycle pulse at the end of an accepted write |
| sector | output | 4 | Sector index of `addr` |
| prog_go | output | 1 | Program grant pulse |
| erase_go | output | 1 | Erase grant pulse |
| blocked | output | 1 | Rejected program/erase pulse |
| blk_sector | output | 4 | Sector index of the rejected request |
| unprot_done | output | 1 | Unlock-all accepted pulse |
| qry_valid | output | 1 | Query result valid |
| qry_prot | output | 1 | Queried lock bit |

## Verification
The assertions check the following on every cycle:
- no grant and `blocked` appear together;
- every grant, `blocked`, `unprot_done` and `qry_valid` pulse follows the matching request from the cycle before;
- `wr_pulse` never lasts two cycles.

Some behaviour depends on history that a simple property cannot follow, so only the directed scenarios can show it:
- the glitch threshold boundary;
- the lockout when the strobes are active at reset;
- the sector map boundaries;
- the return of the locks after the temporary unlock;
- the refusal of unlock-all when only some sectors are locked.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

   // One request from the command decoder, all sampled in the same cycle.
   typedef struct packed {
      logic prog;
      logic erase;
      logic set;
      logic unprot;
      logic qry;
   } fwg_req_t;

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
   parameter int          W           = 1,
   parameter int          SYNC_STAGES = 2,
   parameter logic [W-1:0] RST_VAL    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("fwg_sync: SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] stage [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= RST_VAL;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[SYNC_STAGES-1];

endmodule

// File: rtl/fwg_strobe_qual.sv
module fwg_strobe_qual #(
   parameter int GLITCH_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_s,
   input  logic oe_s,
   input  logic we_s,
   output logic wr_pulse
);

   localparam int CW = $clog2(GLITCH_CYC + 1);

   if (GLITCH_CYC < 1) begin : g_bad_glitch
      $error("fwg_strobe_qual: GLITCH_CYC must be at least 1");
   end

   logic [CW-1:0] hold_cnt;
   logic          armed_ok;   // strobes seen idle since reset
   logic          wr_cond;

   assign wr_cond = !ce_s && !we_s && oe_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt <= '0;
         armed_ok <= 1'b0;
         wr_pulse <= 1'b0;
      end else begin
         wr_pulse <= 1'b0;
         if (!armed_ok) begin
            hold_cnt <= '0;
            if (ce_s && we_s) armed_ok <= 1'b1;
         end else if (wr_cond) begin
            if (hold_cnt != CW'(GLITCH_CYC)) hold_cnt <= hold_cnt + CW'(1);
         end else begin
            wr_pulse <= (hold_cnt == CW'(GLITCH_CYC));
            hold_cnt <= '0;
         end
      end
   end

endmodule

// File: rtl/fwg_sector_map.sv
module fwg_sector_map #(
   parameter int ADDR_W      = 19,
   parameter int BIG_SHIFT   = 16,
   parameter bit BOOT_BOTTOM = 1'b1,
   parameter int NSECT       = 11,
   parameter int SW          = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SW-1:0]     sector
);

   localparam int HW = ADDR_W - BIG_SHIFT;

   // Bottom-boot lookup: within the lowest big block the boot sectors are
   // 1/4, 1/8, 1/8 and 1/2 of it; every later big block is one sector.
   function automatic logic [SW-1:0] bot_idx(input logic [ADDR_W-1:0] a);
      logic [HW-1:0] hi;
      hi = a[ADDR_W-1:BIG_SHIFT];
      if (hi != '0)               return SW'(hi) + SW'(3);
      else if (a[BIG_SHIFT-1])    return SW'(3);
      else if (!a[BIG_SHIFT-2])   return SW'(0);
      else if (a[BIG_SHIFT-3])    return SW'(2);
      else                        return SW'(1);
   endfunction

   if (BOOT_BOTTOM) begin : g_bottom
      always_comb sector = bot_idx(addr);
   end else begin : g_top
      always_comb sector = SW'(NSECT - 1) - bot_idx(~addr);
   end

endmodule

// File: rtl/fwg_protect.sv
module fwg_protect
   import fwg_pkg::*;
#(
   parameter int NSECT = 11,
   parameter int SW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] sector,
   input  fwg_req_t      req,
   input  logic          tmp_s,
   output logic          prog_go,
   output logic          erase_go,
   output logic          blocked,
   output logic [SW-1:0] blk_sector,
   output logic          unprot_done,
   output logic          qry_valid,
   output logic          qry_prot
);

   logic [NSECT-1:0] lock_q;
   logic             cur_lock;
   logic             eff_lock;
   logic             all_lock;

   assign cur_lock = lock_q[sector];
   assign eff_lock = cur_lock && !tmp_s;
   assign all_lock = &lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q      <= '0;
         prog_go     <= 1'b0;
         erase_go    <= 1'b0;
         blocked     <= 1'b0;
         blk_sector  <= '0;
         unprot_done <= 1'b0;
         qry_valid   <= 1'b0;
         qry_prot    <= 1'b0;
      end else begin
         prog_go     <= req.prog  && !eff_lock;
         erase_go    <= req.erase && !eff_lock;
         blocked     <= (req.prog || req.erase) && eff_lock;
         blk_sector  <= ((req.prog || req.erase) && eff_lock) ? sector : '0;
         qry_valid   <= req.qry;
         qry_prot    <= req.qry && cur_lock;
         unprot_done <= 1'b0;
         if (req.unprot) begin
            if (all_lock) begin
               lock_q      <= '0;
               unprot_done <= 1'b1;
            end
         end else if (req.set) begin
            lock_q[sector] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/flash_wrgate.sv
module flash_wrgate
   import fwg_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int BIG_SHIFT   = 16,
   parameter bit BOOT_BOTTOM = 1'b1,
   parameter int GLITCH_CYC  = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NSECT      = 3 + (1 << (ADDR_W - BIG_SHIFT)),
   localparam int SW         = $clog2(NSECT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              tmp_unprot,
   input  logic [ADDR_W-1:0] addr,
   input  logic              prog_req,
   input  logic              erase_req,
   input  logic              prot_set_req,
   input  logic              unprot_req,
   input  logic              qry_req,
   output logic              wr_pulse,
   output logic [SW-1:0]     sector,
   output logic              prog_go,
   output logic              erase_go,
   output logic              blocked,
   output logic [SW-1:0]     blk_sector,
   output logic              unprot_done,
   output logic              qry_valid,
   output logic              qry_prot
);

   if (BIG_SHIFT < 4) begin : g_bad_shift
      $error("flash_wrgate: BIG_SHIFT too small for the boot split");
   end
   if (ADDR_W <= BIG_SHIFT) begin : g_bad_addr
      $error("flash_wrgate: ADDR_W must exceed BIG_SHIFT");
   end

   logic [2:0] strobe_s;   // {ce, oe, we}, active-low levels
   logic       tmp_s;
   fwg_req_t   req;

   // Reset to the active level, so that an idle-high state is seen only
   // once it has really propagated from the pins.
   fwg_sync #(.W(3), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync_strobe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ce_n, oe_n, we_n}),
      .q     (strobe_s)
   );

   fwg_sync #(.W(1), .SYNC_STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_tmp (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tmp_unprot),
      .q     (tmp_s)
   );

   fwg_strobe_qual #(.GLITCH_CYC(GLITCH_CYC)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_s     (strobe_s[2]),
      .oe_s     (strobe_s[1]),
      .we_s     (strobe_s[0]),
      .wr_pulse (wr_pulse)
   );

   fwg_sector_map #(
      .ADDR_W(ADDR_W), .BIG_SHIFT(BIG_SHIFT), .BOOT_BOTTOM(BOOT_BOTTOM),
      .NSECT(NSECT), .SW(SW)
   ) u_map (
      .addr   (addr),
      .sector (sector)
   );

   assign req.prog   = prog_req;
   assign req.erase  = erase_req;
   assign req.set    = prot_set_req;
   assign req.unprot = unprot_req;
   assign req.qry    = qry_req;

   fwg_protect #(.NSECT(NSECT), .SW(SW)) u_prot (
      .clk         (clk),
      .rst_n       (rst_n),
      .sector      (sector),
      .req         (req),
      .tmp_s       (tmp_s),
      .prog_go     (prog_go),
      .erase_go    (erase_go),
      .blocked     (blocked),
      .blk_sector  (blk_sector),
      .unprot_done (unprot_done),
      .qry_valid   (qry_valid),
      .qry_prot    (qry_prot)
   );

endmodule

// File: rtl/flash_wrgate_chk.sv
module flash_wrgate_chk (
   input logic clk,
   input logic rst_n,
   input logic prog_req,
   input logic erase_req,
   input logic unprot_req,
   input logic qry_req,
   input logic wr_pulse,
   input logic prog_go,
   input logic erase_go,
   input logic blocked,
   input logic unprot_done,
   input logic qry_valid
);

   assert_grant_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(blocked && (prog_go || erase_go)));

   assert_prog_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> $past(prog_req));

   assert_erase_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> $past(erase_req));

   assert_blocked_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> $past(prog_req || erase_req));

   assert_unlock_from_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unprot_done |-> $past(unprot_req));

   assert_qry_from_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      qry_valid |-> $past(qry_req));

   assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

endmodule

bind flash_wrgate flash_wrgate_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .prog_req    (prog_req),
   .erase_req   (erase_req),
   .unprot_req  (unprot_req),
   .qry_req     (qry_req),
   .wr_pulse    (wr_pulse),
   .prog_go     (prog_go),
   .erase_go    (erase_go),
   .blocked     (blocked),
   .unprot_done (unprot_done),
   .qry_valid   (qry_valid)
);

// File: tb/flash_wrgate_bench.sv
module flash_wrgate_bench;

   localparam int CLK_PERIOD = 10;
   localparam int GLITCH     = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0, tmp_unprot = 1'b0;
   logic [18:0] addr = '0;
   logic        prog_req = 1'b0, erase_req = 1'b0, prot_set_req = 1'b0;
   logic        unprot_req = 1'b0, qry_req = 1'b0;
   logic        wr_pulse, prog_go, erase_go, blocked, unprot_done, qry_valid, qry_prot;
   logic [3:0]  sector, blk_sector;

   int n_chk = 0, n_bad = 0, n_wr = 0;
   bit done = 0;

   flash_wrgate #(.GLITCH_CYC(GLITCH)) u_flash_wrgate (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .tmp_unprot(tmp_unprot), .addr(addr), .prog_req(prog_req),
      .erase_req(erase_req), .prot_set_req(prot_set_req),
      .unprot_req(unprot_req), .qry_req(qry_req), .wr_pulse(wr_pulse),
      .sector(sector), .prog_go(prog_go), .erase_go(erase_go),
      .blocked(blocked), .blk_sector(blk_sector), .unprot_done(unprot_done),
      .qry_valid(qry_valid), .qry_prot(qry_prot)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (rst_n && wr_pulse) n_wr++;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic logic [18:0] base_of(input int s);
      case (s)
         0: return 19'h00000;
         1: return 19'h04000;
         2: return 19'h06000;
         3: return 19'h08000;
         default: return 19'((s - 3) << 16);
      endcase
   endfunction

   // Hold the write combination for n cycles, then idle for a while.
   task automatic strobe_low(input int n, input logic oe_lvl);
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lvl;
      repeat (n) @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic do_req(input logic [18:0] a, input bit p, input bit e,
                         output bit go, output bit blk, output int bs);
      @(negedge clk); addr = a; prog_req = p; erase_req = e;
      @(negedge clk); prog_req = 1'b0; erase_req = 1'b0;
      go = p ? prog_go : erase_go; blk = blocked; bs = int'(blk_sector);
   endtask

   task automatic query(input logic [18:0] a, output bit v, output bit pr);
      @(negedge clk); addr = a; qry_req = 1'b1;
      @(negedge clk); qry_req = 1'b0; v = qry_valid; pr = qry_prot;
   endtask

   task automatic lock(input int s);
      @(negedge clk); addr = base_of(s); prot_set_req = 1'b1;
      @(negedge clk); prot_set_req = 1'b0;
   endtask

   task automatic unlock_all(output bit ack);
      @(negedge clk); unprot_req = 1'b1;
      @(negedge clk); unprot_req = 1'b0; ack = unprot_done;
   endtask

   task automatic t_reset;
      bit v, pr;
      chk(!wr_pulse && !prog_go && !erase_go && !blocked && !unprot_done && !qry_valid,
          "R4 pulses low after reset", int'(blocked), 0);
      for (int s = 0; s < 11; s++) begin
         query(base_of(s), v, pr);
         chk(v && !pr, "R4 sector unlocked after reset", int'(pr), 0);
      end
   endtask

   task automatic t_lockout;
      int w0 = n_wr;
      repeat (8) @(negedge clk);
      we_n = 1'b1;                 // only write enable rises
      repeat (5) @(negedge clk);
      we_n = 1'b0;
      repeat (5) @(negedge clk);
      we_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(n_wr == w0, "R3 no write before idle seen", n_wr - w0, 0);
      ce_n = 1'b1;
      repeat (4) @(negedge clk);
      strobe_low(5, 1'b1);
      chk(n_wr == w0 + 1, "R3 write accepted after idle", n_wr - w0, 1);
   endtask

   task automatic t_write_basic;
      int w0 = n_wr;
      strobe_low(4, 1'b1);
      strobe_low(8, 1'b1);
      chk(n_wr == w0 + 2, "R1 one pulse per write cycle", n_wr - w0, 2);
   endtask

   task automatic t_inhibit;
      int w0 = n_wr;
      strobe_low(6, 1'b0);         // output enable low
      chk(n_wr == w0, "R1 oe low inhibits", n_wr - w0, 0);
      @(negedge clk); ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1;
      repeat (6) @(negedge clk); we_n = 1'b1; repeat (6) @(negedge clk);
      chk(n_wr == w0, "R1 ce high inhibits", n_wr - w0, 0);
      @(negedge clk); ce_n = 1'b0; we_n = 1'b1;
      repeat (6) @(negedge clk); ce_n = 1'b1; repeat (6) @(negedge clk);
      chk(n_wr == w0, "R1 we high inhibits", n_wr - w0, 0);
   endtask

   task automatic t_glitch;
      int w0 = n_wr;
      strobe_low(GLITCH - 1, 1'b1);
      chk(n_wr == w0, "R2 short pulse rejected", n_wr - w0, 0);
      strobe_low(1, 1'b1);
      chk(n_wr == w0, "R2 one-cycle glitch rejected", n_wr - w0, 0);
      strobe_low(GLITCH, 1'b1);
      chk(n_wr == w0 + 1, "R2 threshold pulse accepted", n_wr - w0, 1);
   endtask

   task automatic t_map;
      logic [18:0] a [12] = '{19'h00000, 19'h03FFF, 19'h04000, 19'h05FFF,
                              19'h06000, 19'h07FFF, 19'h08000, 19'h0FFFF,
                              19'h10000, 19'h45678, 19'h6FFFF, 19'h7FFFF};
      int e [12] = '{0, 0, 1, 1, 2, 2, 3, 3, 4, 7, 9, 10};
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); addr = a[i]; #1;
         chk(int'(sector) == e[i], "R5 sector map", int'(sector), e[i]);
      end
   endtask

   task automatic t_protect;
      bit go, blk, v, pr; int bs;
      lock(3);
      do_req(19'h09000, 1'b1, 1'b0, go, blk, bs);
      chk(!go && blk, "R6 program to locked sector blocked", int'(go), 0);
      chk(bs == 3, "R6 blocked sector index", bs, 3);
      do_req(19'h0C000, 1'b0, 1'b1, go, blk, bs);
      chk(!go && blk && bs == 3, "R6 erase to locked sector blocked", int'(go), 0);
      do_req(19'h10000, 1'b0, 1'b1, go, blk, bs);
      chk(go && !blk, "R6 erase to unlocked sector granted", int'(go), 1);
      do_req(19'h05000, 1'b1, 1'b0, go, blk, bs);
      chk(go && !blk, "R6 program to unlocked sector granted", int'(go), 1);
      query(19'h08000, v, pr);
      chk(v && pr, "R9 query reads lock bit", int'(pr), 1);
   endtask

   task automatic t_temp;
      bit go, blk, v, pr; int bs;
      @(negedge clk); tmp_unprot = 1'b1;
      repeat (4) @(negedge clk);
      do_req(19'h09000, 1'b1, 1'b0, go, blk, bs);
      chk(go && !blk, "R7 temp unlock grants program", int'(go), 1);
      do_req(19'h08000, 1'b0, 1'b1, go, blk, bs);
      chk(go && !blk, "R7 temp unlock grants erase", int'(go), 1);
      query(19'h08000, v, pr);
      chk(v && pr, "R9 stored bit unaffected by temp unlock", int'(pr), 1);
      @(negedge clk); tmp_unprot = 1'b0;
      repeat (4) @(negedge clk);
      do_req(19'h09000, 1'b1, 1'b0, go, blk, bs);
      chk(!go && blk, "R7 lock restored after temp unlock", int'(blk), 1);
   endtask

   task automatic t_unlock;
      bit ack, v, pr;
      unlock_all(ack);
      chk(!ack, "R8 unlock refused when partly locked", int'(ack), 0);
      query(19'h08000, v, pr);
      chk(pr, "R8 lock kept after refusal", int'(pr), 1);
      for (int s = 0; s < 11; s++) lock(s);
      unlock_all(ack);
      chk(ack, "R8 unlock accepted when all locked", int'(ack), 1);
      for (int s = 0; s < 11; s++) begin
         query(base_of(s), v, pr);
         chk(v && !pr, "R8 all sectors unlocked", int'(pr), 0);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;              // strobes still in the write combination
      t_reset();
      t_lockout();
      t_write_basic();
      t_inhibit();
      t_glitch();
      t_map();
      t_protect();
      t_temp();
      t_unlock();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule